// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is a purely combinational datapath unit for a scalar integer core. It takes two 32-bit operands and a 4-bit operation code, and returns one 32-bit result. It covers add, subtract, signed and unsigned compare-to-flag, the three bitwise operations, and three shifts: left logical, right logical and right arithmetic.

Register-immediate instructions reuse the same operation codes. Upstream decode places the sign-extended 12-bit immediate on operand B. Choosing between a register and an immediate, decoding and writeback all belong to the surrounding pipeline. No register sits on the path, so the result follows the inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: Code 0 (ADD) returns A + B modulo 2^32; overflow wraps silently and raises no flag.
- R2: Code 1 (SUB) returns A - B modulo 2^32, wrapping silently.
- R3: Code 2 (SLT) returns 1 when A is less than B as two's-complement numbers, else 0; bits 31..1 of the result are zero.
- R4: Code 3 (SLTU) returns 1 when A is less than B as unsigned numbers, else 0. A sign-extended immediate on B is compared as its unsigned bit pattern, so 0xFFFFF800 is larger than any small A.
- R5: Codes 4, 5 and 6 return the bitwise XOR, OR and AND of A and B over all 32 bits.
- R6: Code 7 (SLL) shifts A left, filling vacated low bits with zeros.
- R7: Code 8 (SRL) shifts A right, filling vacated high bits with zeros.
- R8: Code 9 (SRA) shifts A right, filling vacated high bits with copies of A[31].
- R9: Shifts use only B[4:0] as the amount. B[31:5] has no effect, and an amount of 0 returns A unchanged.
- R10: Codes 10 through 15 are unused and return 0.
- R11: The result depends only on the current inputs. It settles without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code, encoded as listed in R1 through R10 |
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand, or the sign-extended immediate; its low 5 bits give the shift amount |
| result | output | 32 | Result of the selected operation |

## Verification
The block holds no state, so every fault shows on `result` at once, for the inputs that exercise it. A wrong borrow or sign path shows only near the sign boundaries, for example 0x80000000 against 0x7FFFFFFF, or 0 against 0xFFFFFFFF. A wrong fill or a wrong shifter stage shows only at particular shift amounts. For that reason the stimulus sweeps every amount from 0 to 31 for each shift, with junk in B[31:5], and uses operands whose top bit is both set and clear.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int XLEN_DEF = 32;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_SLT  = 4'd2,
        ALU_SLTU = 4'd3,
        ALU_XOR  = 4'd4,
        ALU_OR   = 4'd5,
        ALU_AND  = 4'd6,
        ALU_SLL  = 4'd7,
        ALU_SRL  = 4'd8,
        ALU_SRA  = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic lt_signed;
        logic lt_unsigned;
    } cmp_flags_t;

    function automatic logic op_is_compare(input alu_op_e op);
        return (op == ALU_SLT) || (op == ALU_SLTU);
    endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic         borrow
);
    logic [W:0] diff_ext;

    // Wrap-around sum: the carry out is discarded on purpose.
    assign sum      = a + b;
    assign diff_ext = {1'b0, a} - {1'b0, b};
    assign diff     = diff_ext[W-1:0];
    assign borrow   = diff_ext[W];
endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_flags_t   flags
);
    assign flags.lt_signed   = $signed(a) < $signed(b);
    assign flags.lt_unsigned = a < b;
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] x_out,
    output logic [W-1:0] o_out,
    output logic [W-1:0] n_out
);
    assign x_out = a ^ b;
    assign o_out = a | b;
    assign n_out = a & b;

    always_comb begin
        a_r5_xor_consistent: assert (x_out == (o_out & ~n_out));
    end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] shamt,
    input  logic           dir_left,
    input  logic           arith,
    output logic [W-1:0]   res
);
    logic           fill;
    logic [W-1:0]   a_rev;
    logic [W-1:0]   out_rev;
    logic [W-1:0]   stage [0:SHW];

    // A left shift is done as a right shift of the bit-reversed word.
    assign fill = arith & ~dir_left & a[W-1];

    always_comb begin
        for (int i = 0; i < W; i++) a_rev[i] = a[W-1-i];
    end

    assign stage[0] = dir_left ? a_rev : a;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = shamt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
    end

    always_comb begin
        for (int i = 0; i < W; i++) out_rev[i] = stage[SHW][W-1-i];
    end

    assign res = dir_left ? out_rev : stage[SHW];

    always_comb begin
        if (shamt == '0) begin
            a_r9_zero_amount: assert (res == a);
        end
        if (arith && !dir_left) begin
            a_r8_sign_fill: assert (res[W-1] == a[W-1]);
        end
        if (!arith && !dir_left && shamt != '0) begin
            a_r7_zero_fill: assert (res[W-1] == 1'b0);
        end
        if (dir_left && shamt != '0) begin
            a_r6_zero_fill: assert (res[0] == 1'b0);
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result
);
    localparam int SHW = $clog2(XLEN);

    alu_op_e         op;
    logic [XLEN-1:0] sum, diff, x_r, o_r, n_r, sh_r;
    logic            borrow;
    cmp_flags_t      flags;

    assign op = alu_op_e'(op_sel);

    int_alu_addsub #(.W(XLEN)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sum(sum), .diff(diff), .borrow(borrow)
    );

    int_alu_cmp #(.W(XLEN)) u_cmp (
        .a(opnd_a), .b(opnd_b), .flags(flags)
    );

    int_alu_logic #(.W(XLEN)) u_logic (
        .a(opnd_a), .b(opnd_b), .x_out(x_r), .o_out(o_r), .n_out(n_r)
    );

    int_alu_shift #(.W(XLEN)) u_shift (
        .a(opnd_a),
        .shamt(opnd_b[SHW-1:0]),
        .dir_left(op == ALU_SLL),
        .arith(op == ALU_SRA),
        .res(sh_r)
    );

    always_comb begin
        unique case (op)
            ALU_ADD:  result = sum;
            ALU_SUB:  result = diff;
            ALU_SLT:  result = {{(XLEN-1){1'b0}}, flags.lt_signed};
            ALU_SLTU: result = {{(XLEN-1){1'b0}}, flags.lt_unsigned};
            ALU_XOR:  result = x_r;
            ALU_OR:   result = o_r;
            ALU_AND:  result = n_r;
            ALU_SLL,
            ALU_SRL,
            ALU_SRA:  result = sh_r;
            default:  result = '0;
        endcase
    end

    // Cross-checks between the comparator and the subtractor.
    always_comb begin
        if (opnd_a[XLEN-1] == opnd_b[XLEN-1]) begin
            a_r3_slt_vs_diff: assert (flags.lt_signed == diff[XLEN-1]);
        end
        if (opnd_a[XLEN-1] != opnd_b[XLEN-1]) begin
            a_r3_slt_mixed_sign: assert (flags.lt_signed == opnd_a[XLEN-1]);
        end
        a_r4_sltu_vs_borrow: assert (flags.lt_unsigned == borrow);
        if (op_is_compare(op)) begin
            a_r3_flag_zero_ext: assert (result[XLEN-1:1] == '0);
        end
    end
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 23;

    localparam logic [3:0] V_OP [0:N_VEC-1] = '{
        4'd0, 4'd0, 4'd1, 4'd1, 4'd2, 4'd2, 4'd2, 4'd3, 4'd3, 4'd3,
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd9, 4'd8, 4'd7, 4'd9,
        4'd0, 4'd15, 4'd2};
    localparam logic [31:0] V_A [0:N_VEC-1] = '{
        32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h80000000,
        32'h7FFFFFFF, 32'h00000005, 32'h80000000, 32'h00000000, 32'h00000005,
        32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'h00000001, 32'h80000000,
        32'h80000000, 32'h80000000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF,
        32'h0000000A, 32'h0000007B, 32'hFFFFFFFF};
    localparam logic [31:0] V_B [0:N_VEC-1] = '{
        32'h00000001, 32'h00000001, 32'h00000001, 32'h00000001, 32'h7FFFFFFF,
        32'h80000000, 32'h00000005, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'hFFFFF800,
        32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00, 32'h0000001F, 32'h0000001F,
        32'h0000001F, 32'h00000000, 32'h00000020, 32'hFFFFFFE1, 32'h00000004,
        32'hFFFFFFFF, 32'h000001C8, 32'h00000000};
    localparam logic [31:0] V_EXP [0:N_VEC-1] = '{
        32'h80000000, 32'h00000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000001,
        32'h00000000, 32'h00000000, 32'h00000000, 32'h00000001, 32'h00000001,
        32'h0FF00FF0, 32'hFFF0FFF0, 32'hF000F000, 32'h80000000, 32'h00000001,
        32'hFFFFFFFF, 32'h80000000, 32'h80000000, 32'h00000002, 32'h07FFFFFF,
        32'h00000009, 32'h00000000, 32'h00000001};
    localparam string V_REQ [0:N_VEC-1] = '{
        "R1", "R1", "R2", "R2", "R3", "R3", "R3", "R4", "R4", "R4",
        "R5", "R5", "R5", "R6", "R7", "R8", "R9", "R9", "R9", "R8",
        "R1", "R10", "R3"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    int_alu u_int_alu (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: op=%0d a=%h b=%h got %h expected %h",
                     req, op_sel, opnd_a, opnd_b, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [31:0] va, vb, sa, exp_v;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset state: ADD of zero operands gives zero.
        apply(4'd0, 32'h0, 32'h0);
        check("R1", result, 32'h0);

        // Vector table walk.
        for (int i = 0; i < N_VEC; i++) begin
            apply(V_OP[i], V_A[i], V_B[i]);
            check(V_REQ[i], result, V_EXP[i]);
        end

        // R9, R6, R7, R8: every shift amount with junk in the upper bits of B.
        for (int sh = 0; sh < 32; sh++) begin
            vb = {27'h5A5A5A5, sh[4:0]};
            va = 32'h87654321;
            apply(4'd7, va, vb);
            check("R6", result, va << sh);
            apply(4'd8, va, vb);
            check("R7", result, va >> sh);
            apply(4'd9, va, vb);
            sa = 32'($signed(va) >>> sh);
            check("R8", result, sa);
            apply(4'd9, 32'h12345678, vb);
            check("R9", result, 32'h12345678 >> sh);
        end

        // R1 to R4 over a pseudo-random operand sequence.
        va = 32'hACE1_2468;
        vb = 32'h1357_9BDF;
        for (int k = 0; k < 40; k++) begin
            va = {va[30:0], va[31] ^ va[21] ^ va[1] ^ va[0]};
            vb = vb * 32'd1664525 + 32'd1013904223;
            apply(4'd0, va, vb); check("R1", result, va + vb);
            apply(4'd1, va, vb); check("R2", result, va - vb);
            exp_v = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
            apply(4'd2, va, vb); check("R3", result, exp_v);
            exp_v = (va < vb) ? 32'd1 : 32'd0;
            apply(4'd3, va, vb); check("R4", result, exp_v);
            apply(4'd4, va, vb); check("R5", result, va ^ vb);
        end

        // R10: every unused code returns zero.
        for (int c = 10; c < 16; c++) begin
            apply(c[3:0], 32'hFFFFFFFF, 32'h12345678);
            check("R10", result, 32'h0);
        end

        // R11: the output follows an input change with no clock edge in between.
        @(posedge clk);
        #1;
        op_sel = 4'd0; opnd_a = 32'd100; opnd_b = 32'd23;
        #1;
        check("R11", result, 32'd123);
        opnd_b = 32'd24;
        #1;
        check("R11", result, 32'd124);

        finish_run();
    end
endmodule